// File: doc/BRIEF.md
# NAND Page Operation Sequencer

This block runs whole NAND flash page operations on its own. Software or a higher-level controller gives it an operation code, a 24-bit page (row) address and a 16-bit column address, and pulses `start`. The sequencer then drives a byte-wide flash bus port, which it assumes handles the pin-level timing. Each beat on that port is one command byte, one address byte or one data byte, and each beat finishes in a single cycle. The sequencer holds chip enable for the whole operation. It sends the command bytes and address bytes in the order the flash expects. It then waits for the device's busy-to-ready edge and moves the payload.

Five operations are supported: device reset, page read, spare-area read, page program and block erase. Program data is taken from an input byte stream with a valid/ready handshake. Read data leaves on an output byte stream that pulses valid once per byte. After a program or erase, the sequencer reads the device status byte and reports the result. Every ready wait is guarded by a cycle-count limit. If the limit runs out, the operation aborts, chip enable drops and a timeout flag is raised.

Top module: `nand_page_seq`

## Requirements
- R1: Operation code 0 (reset) sends command 0xFF with chip enable high. It then waits for a new busy-to-ready edge on `fl_rb`, drops chip enable and pulses `done`. Bus beat kinds on `fl_kind` are 0 for command, 1 for address and 2 for data.
- R2: Operation code 1 (page read) sends command 0x00, five address bytes and command 0x30. It then waits for ready and reads PAGE_BYTES bytes from `fl_rdata`, presenting each one on `rd_data` with a one-cycle `rd_valid`.
- R3: The five address bytes of a read, spare read or program go out in this order: column bits 7:0, column bits 15:8, row bits 7:0, row bits 15:8, row bits 23:16.
- R4: Operation code 2 (spare read) behaves like a page read but ignores the `col` input and uses the column PAGE_BYTES. It returns SPARE_BYTES bytes.
- R5: Operation code 3 (program) sends command 0x80, the five address bytes, and PAGE_BYTES data beats taken in order from the write stream. The sequencer stalls while `wr_valid` is low. It then sends command 0x10, waits for ready, sends command 0x70 and makes exactly one read of the status byte.
- R6: `prog_fail` takes bit 0 of the status byte from the last program or erase. The other status bits, including the ready bit 6, have no effect. The flag is cleared when the next operation is accepted.
- R7: Operation code 4 (erase) sends command 0x60, then three row address bytes (bits 7:0, 15:8, 23:16), then command 0xD0. It waits for ready and then does the same status check as a program.
- R8: The latched ready edge is cleared every time a command byte is sent. A ready edge seen before the last command of a phase does not end the wait that follows it.
- R9: If a ready wait lasts more than `tmo_limit` cycles, the operation aborts. No data beats or status read follow, chip enable drops, `timeout` is set until the next accepted operation, and `done` pulses.
- R10: `start` is accepted only in the idle state and only with codes 0 to 4. Any other request has no effect. `done` is high for exactly one cycle per operation.
- R11: Chip enable is high from the first command byte through the last beat of the operation, and every bus beat occurs while chip enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operation request |
| op | input | 3 | Operation code (0 reset, 1 read, 2 spare read, 3 program, 4 erase) |
| row | input | 24 | Page address |
| col | input | 16 | Column address |
| tmo_limit | input | TMO_W | Ready-wait limit in cycles |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data byte present |
| wr_ready | output | 1 | Program byte consumed when valid is also high |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read data byte strobe |
| done | output | 1 | One-cycle end-of-operation pulse |
| prog_fail | output | 1 | Program/erase failure from status bit 0 |
| timeout | output | 1 | Last operation aborted on a ready wait |
| fl_ce | output | 1 | Flash chip enable (active high) |
| fl_wr | output | 1 | Write beat strobe |
| fl_kind | output | 2 | Beat kind: 0 command, 1 address, 2 data |
| fl_wdata | output | 8 | Write beat byte |
| fl_rd | output | 1 | Read beat strobe |
| fl_rdata | input | 8 | Byte returned by the port during a read beat |
| fl_rb | input | 1 | Device ready (1) / busy (0) |

## Verification
The bench's flash model can pulse ready low and back high during the address phase, and it returns 0xEE while busy. A sequencer that did not clear the latched edge at the second command would therefore stream 0xEE bytes instead of page data. A stuck-busy model shows whether an aborting design still tries to read data or leaves chip enable high. The bench also sends a program stream with random stalls and status bytes with bit 6 set and bit 0 varied, which exposes data loss, duplicated bytes and a status check on the wrong bit. Spare reads with a nonzero `col`, and a `start` pulse sent in the middle of an operation, catch a design that uses the caller's column or restarts while busy.

// File: rtl/nsq_pkg.sv
package nsq_pkg;

    typedef enum logic [2:0] {
        OP_RESET = 3'd0,
        OP_READ  = 3'd1,
        OP_SPARE = 3'd2,
        OP_PROG  = 3'd3,
        OP_ERASE = 3'd4
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_CMD1, S_ADDR, S_WDATA, S_CMD2,
        S_WAIT, S_RDATA, S_STCMD, S_STRD, S_FINISH
    } state_e;

    typedef enum logic [1:0] {
        K_CMD  = 2'd0,
        K_ADDR = 2'd1,
        K_DATA = 2'd2
    } kind_e;

    typedef struct packed {
        op_e         op;
        logic [23:0] row;
        logic [15:0] col;
    } req_t;

    localparam logic [7:0] CMD_STATUS = 8'h70;

    function automatic logic op_known(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

    function automatic logic [7:0] cmd_first(input op_e o);
        case (o)
            OP_READ, OP_SPARE: return 8'h00;
            OP_PROG:           return 8'h80;
            OP_ERASE:          return 8'h60;
            default:           return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] cmd_second(input op_e o);
        case (o)
            OP_READ, OP_SPARE: return 8'h30;
            OP_PROG:           return 8'h10;
            OP_ERASE:          return 8'hD0;
            default:           return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] addr_byte(input logic [2:0] idx,
                                             input logic [15:0] c,
                                             input logic [23:0] r);
        case (idx)
            3'd0:    return c[7:0];
            3'd1:    return c[15:8];
            3'd2:    return r[7:0];
            3'd3:    return r[15:8];
            default: return r[23:16];
        endcase
    endfunction

endpackage

// File: rtl/nsq_ready_latch.sv
module nsq_ready_latch (
    input  logic clk,
    input  logic rst,
    input  logic rb,
    input  logic clr,
    output logic flag
);
    logic rb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rb_q <= 1'b1;
            flag <= 1'b0;
        end else begin
            rb_q <= rb;
            if (clr)
                flag <= 1'b0;
            else if (rb && !rb_q)
                flag <= 1'b1;
        end
    end

    // R8: the flag only rises after a real low-to-high ready change with no command clearing it
    a_r8_flag_from_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(rb && !rb_q && !clr));

endmodule

// File: rtl/nsq_wait_timer.sv
module nsq_wait_timer #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt != limit)
            cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == limit);

    // R9: the count never passes the limit while a wait is running
    a_r9_count_bounded: assert property (@(posedge clk) disable iff (rst)
        run && $past(run) && $past(cnt != limit) |-> cnt == $past(cnt) + 1'b1);

endmodule

// File: rtl/nand_page_seq.sv
module nand_page_seq
    import nsq_pkg::*;
#(
    parameter int PAGE_BYTES  = 2048,
    parameter int SPARE_BYTES = 16,
    parameter int TMO_W       = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [2:0]       op,
    input  logic [23:0]      row,
    input  logic [15:0]      col,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             done,
    output logic             prog_fail,
    output logic             timeout,
    output logic             fl_ce,
    output logic             fl_wr,
    output logic [1:0]       fl_kind,
    output logic [7:0]       fl_wdata,
    output logic             fl_rd,
    input  logic [7:0]       fl_rdata,
    input  logic             fl_rb
);
    localparam int CNT_W = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;
    localparam logic [CNT_W-1:0] PAGE_LAST  = CNT_W'(PAGE_BYTES - 1);
    localparam logic [CNT_W-1:0] SPARE_LAST = CNT_W'(SPARE_BYTES - 1);
    localparam logic [15:0]      SPARE_COL  = 16'(PAGE_BYTES);

    state_e           state;
    req_t             req;
    logic [2:0]       aidx;
    logic [CNT_W-1:0] cnt;
    logic             rdy_flag;
    logic             tmo_hit;
    logic             cmd_issue;
    logic [CNT_W-1:0] rd_last;

    assign cmd_issue = fl_wr && (fl_kind == K_CMD);
    assign rd_last   = (req.op == OP_SPARE) ? SPARE_LAST : PAGE_LAST;

    nsq_ready_latch u_ready (
        .clk  (clk),
        .rst  (rst),
        .rb   (fl_rb),
        .clr  (cmd_issue),
        .flag (rdy_flag)
    );

    nsq_wait_timer #(.W(TMO_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state == S_WAIT),
        .limit   (tmo_limit),
        .expired (tmo_hit)
    );

    // Bus beats and stream strobes, decoded from the current state
    always_comb begin
        fl_wr    = 1'b0;
        fl_kind  = K_CMD;
        fl_wdata = 8'h00;
        fl_rd    = 1'b0;
        wr_ready = 1'b0;
        rd_valid = 1'b0;
        case (state)
            S_CMD1: begin
                fl_wr    = 1'b1;
                fl_wdata = cmd_first(req.op);
            end
            S_ADDR: begin
                fl_wr    = 1'b1;
                fl_kind  = K_ADDR;
                fl_wdata = addr_byte(aidx, req.col, req.row);
            end
            S_WDATA: begin
                wr_ready = 1'b1;
                fl_wr    = wr_valid;
                fl_kind  = K_DATA;
                fl_wdata = wr_data;
            end
            S_CMD2: begin
                fl_wr    = 1'b1;
                fl_wdata = cmd_second(req.op);
            end
            S_STCMD: begin
                fl_wr    = 1'b1;
                fl_wdata = CMD_STATUS;
            end
            S_RDATA: begin
                fl_rd    = 1'b1;
                rd_valid = 1'b1;
            end
            S_STRD:  fl_rd = 1'b1;
            default: ;
        endcase
    end

    assign rd_data = fl_rdata;
    assign done    = (state == S_FINISH);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            req       <= '0;
            aidx      <= '0;
            cnt       <= '0;
            fl_ce     <= 1'b0;
            prog_fail <= 1'b0;
            timeout   <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (start && op_known(op)) begin
                    req.op    <= op_e'(op);
                    req.row   <= row;
                    req.col   <= (op_e'(op) == OP_SPARE) ? SPARE_COL : col;
                    fl_ce     <= 1'b1;
                    prog_fail <= 1'b0;
                    timeout   <= 1'b0;
                    state     <= S_CMD1;
                end
                S_CMD1: begin
                    aidx  <= (req.op == OP_ERASE) ? 3'd2 : 3'd0;
                    state <= (req.op == OP_RESET) ? S_WAIT : S_ADDR;
                end
                S_ADDR: begin
                    aidx <= aidx + 3'd1;
                    if (aidx == 3'd4) begin
                        cnt   <= '0;
                        state <= (req.op == OP_PROG) ? S_WDATA : S_CMD2;
                    end
                end
                S_WDATA: if (wr_valid) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == PAGE_LAST) state <= S_CMD2;
                end
                S_CMD2: state <= S_WAIT;
                S_WAIT: begin
                    if (rdy_flag) begin
                        cnt <= '0;
                        case (req.op)
                            OP_RESET:          state <= S_FINISH;
                            OP_READ, OP_SPARE: state <= S_RDATA;
                            default:           state <= S_STCMD;
                        endcase
                    end else if (tmo_hit) begin
                        timeout <= 1'b1;
                        state   <= S_FINISH;
                    end
                end
                S_RDATA: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == rd_last) state <= S_FINISH;
                end
                S_STCMD: state <= S_STRD;
                S_STRD: begin
                    prog_fail <= fl_rdata[0];
                    state     <= S_FINISH;
                end
                S_FINISH: begin
                    fl_ce <= 1'b0;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R11: every bus beat happens under chip enable
    a_r11_beat_under_ce: assert property (@(posedge clk) disable iff (rst)
        (fl_wr || fl_rd) |-> fl_ce);

    // R10: done lasts one cycle and returns the sequencer to idle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && state == S_IDLE);

    // R10: chip enable stays low while idle without a request
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && !start) |=> !fl_ce);

    // R9: timeout only rises out of a ready wait, and no read follows it
    a_r9_timeout_origin: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout) |-> $past(state == S_WAIT) && done);

    // R6: failure flag only rises after a status read
    a_r6_fail_after_status: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_fail) |-> $past(state == S_STRD));

    // R5: write and read beats never coincide
    a_r5_one_beat: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fl_wr, fl_rd}));

endmodule

// File: tb/nand_page_seq_bench.sv
module nand_page_seq_bench;
    localparam int PB   = 32;
    localparam int SB   = 8;
    localparam int TW   = 12;
    localparam int BUSY = 15;
    localparam int LOGN = 1024;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [2:0] op_i = 3'd0;
    logic [23:0] row_i = '0;
    logic [15:0] col_i = '0;
    logic [TW-1:0] tmo = 12'd200;
    logic [7:0] wr_data = 8'h00;
    logic wr_valid = 1'b0;
    logic wr_ready, rd_valid, done, prog_fail, timeout;
    logic [7:0] rd_data;
    logic fl_ce, fl_wr, fl_rd, fl_rb;
    logic [1:0] fl_kind;
    logic [7:0] fl_wdata, fl_rdata;

    always #2 clk = ~clk;

    nand_page_seq #(.PAGE_BYTES(PB), .SPARE_BYTES(SB), .TMO_W(TW)) u_nand_page_seq (
        .clk(clk), .rst(rst), .start(start), .op(op_i), .row(row_i), .col(col_i),
        .tmo_limit(tmo), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .prog_fail(prog_fail),
        .timeout(timeout), .fl_ce(fl_ce), .fl_wr(fl_wr), .fl_kind(fl_kind),
        .fl_wdata(fl_wdata), .fl_rd(fl_rd), .fl_rdata(fl_rdata), .fl_rb(fl_rb)
    );

    // ---------------- flash device model ----------------
    int   busy_cnt = 0;
    bit   hang = 0, fail_bit = 0, glitch_en = 0;
    logic glitch_pend = 0, glitch_low = 0, in_status = 0;
    logic [15:0] colptr = '0;
    logic [7:0]  rowlo = '0;
    int   addr_n = 0;

    always @(posedge clk) begin
        if (busy_cnt > 0 && !hang) busy_cnt <= busy_cnt - 1;
        glitch_low  <= glitch_pend;
        glitch_pend <= 1'b0;
        if (fl_rd && !in_status) colptr <= colptr + 16'd1;
        if (fl_wr && fl_kind == 2'd0) begin
            in_status <= (fl_wdata == 8'h70);
            addr_n    <= 0;
            if (fl_wdata == 8'hFF || fl_wdata == 8'h30 || fl_wdata == 8'h10 || fl_wdata == 8'hD0)
                busy_cnt <= BUSY;
        end else if (fl_wr && fl_kind == 2'd1) begin
            addr_n <= addr_n + 1;
            if (addr_n == 0) begin
                colptr[7:0] <= fl_wdata;
                if (glitch_en) glitch_pend <= 1'b1;
            end
            if (addr_n == 1) colptr[15:8] <= fl_wdata;
            if (addr_n == 2) rowlo <= fl_wdata;
        end
    end

    assign fl_rb    = (busy_cnt == 0) && !glitch_low;
    assign fl_rdata = !fl_rb ? 8'hEE :
                      in_status ? {1'b0, 1'b1, 5'b10101, fail_bit} :
                      (rowlo ^ colptr[7:0] ^ 8'h5A);

    // ---------------- monitors ----------------
    logic [9:0] logbuf [LOGN];
    logic [7:0] rbuf   [LOGN];
    int ln = 0, rn = 0, dn = 0, bad_ce = 0;

    always @(posedge clk) begin
        if (fl_wr) begin logbuf[ln % LOGN] <= {fl_kind, fl_wdata}; ln <= ln + 1; end
        if (rd_valid) begin rbuf[rn % LOGN] <= rd_data; rn <= rn + 1; end
        if (done) dn <= dn + 1;
    end
    always @(negedge clk) if (!rst && (fl_wr || fl_rd) && !fl_ce) bad_ce++;

    // ---------------- program stream source ----------------
    logic [7:0] pdata [256];
    int pidx = 0;
    always @(negedge clk) begin
        wr_valid = (($urandom % 4) != 0);
        wr_data  = pdata[pidx % 256];
    end
    always @(posedge clk) if (wr_valid && wr_ready) pidx <= pidx + 1;

    // ---------------- checking ----------------
    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [9:0] exp_log [64 + PB];
    int exp_n;

    task automatic push(input logic [1:0] k, input logic [7:0] b);
        exp_log[exp_n] = {k, b};
        exp_n++;
    endtask

    function automatic logic [7:0] read_exp(input logic [23:0] r, input logic [15:0] c, input int k);
        logic [15:0] cc;
        cc = c + 16'(k);
        return r[7:0] ^ cc[7:0] ^ 8'h5A;
    endfunction

    task automatic build_exp(input logic [2:0] o, input logic [23:0] r, input logic [15:0] c, input int pb);
        logic [7:0] first, second;
        exp_n = 0;
        case (o)
            3'd0: begin first = 8'hFF; second = 8'hFF; end
            3'd1, 3'd2: begin first = 8'h00; second = 8'h30; end
            3'd3: begin first = 8'h80; second = 8'h10; end
            default: begin first = 8'h60; second = 8'hD0; end
        endcase
        push(2'd0, first);
        if (o != 3'd0) begin
            if (o != 3'd4) begin push(2'd1, c[7:0]); push(2'd1, c[15:8]); end
            push(2'd1, r[7:0]); push(2'd1, r[15:8]); push(2'd1, r[23:16]);
            if (o == 3'd3)
                for (int k = 0; k < PB; k++) push(2'd2, pdata[(pb + k) % 256]);
            push(2'd0, second);
            if (o == 3'd3 || o == 3'd4) push(2'd0, 8'h70);
        end
    endtask

    task automatic run_op(input logic [2:0] o, input logic [23:0] r, input logic [15:0] c,
                          input bit poke, input bit tmo_exp, input string tag);
        int lb, rb0, d0, pb, w, nrd;
        logic [15:0] ceff;
        bit logok;
        lb = ln; rb0 = rn; d0 = dn; pb = pidx;
        for (int k = 0; k < PB; k++) pdata[(pb + k) % 256] = 8'($urandom);
        ceff = (o == 3'd2) ? 16'(PB) : c;
        build_exp(o, r, ceff, pb);
        if (tmo_exp && (o == 3'd3 || o == 3'd4)) exp_n--;
        @(negedge clk); start = 1'b1; op_i = o; row_i = r; col_i = c;
        @(negedge clk); start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1'b1; op_i = 3'd3;
            @(negedge clk); start = 1'b0;
        end
        w = 0;
        while (!done && w < 5000) begin @(negedge clk); w++; end
        chk(done == 1'b1, {tag, " done reached"}, done, 1);
        @(negedge clk);
        chk(done == 1'b0 && dn - d0 == 1, {tag, " R10 single done pulse"}, dn - d0, 1);
        chk(fl_ce == 1'b0, {tag, " R11 ce released"}, fl_ce, 0);
        chk(ln - lb == exp_n, {tag, " beat count"}, ln - lb, exp_n);
        logok = 1;
        for (int k = 0; k < exp_n && k < ln - lb; k++)
            if (logok && logbuf[(lb + k) % LOGN] !== exp_log[k]) begin
                logok = 0;
                chk(0, {tag, " beat sequence"}, logbuf[(lb + k) % LOGN], exp_log[k]);
            end
        if (logok) chk(1, tag, 0, 0);
        nrd = tmo_exp ? 0 : (o == 3'd1) ? PB : (o == 3'd2) ? SB : 0;
        chk(rn - rb0 == nrd, {tag, " read byte count"}, rn - rb0, nrd);
        if (nrd > 0) begin
            logok = 1;
            for (int k = 0; k < nrd && k < rn - rb0; k++)
                if (logok && rbuf[(rb0 + k) % LOGN] !== read_exp(r, ceff, k)) begin
                    logok = 0;
                    chk(0, {tag, " read data"}, rbuf[(rb0 + k) % LOGN], read_exp(r, ceff, k));
                end
            if (logok) chk(1, tag, 0, 0);
        end
        chk(timeout == tmo_exp, {tag, " R9 timeout flag"}, timeout, tmo_exp);
        if ((o == 3'd3 || o == 3'd4) && !tmo_exp)
            chk(prog_fail == fail_bit, {tag, " R6 status bit0"}, prog_fail, fail_bit);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        int d0, l0;
        logic [2:0] rop;
        seed = $urandom(32'd2024);
        repeat (4) @(negedge clk);
        // reset state
        chk(fl_ce == 0 && done == 0 && fl_wr == 0 && fl_rd == 0, "R11 reset quiet", {fl_ce, done, fl_wr, fl_rd}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(wr_ready == 0 && rd_valid == 0, "R10 idle strobes", {wr_ready, rd_valid}, 0);

        run_op(3'd0, 24'h0, 16'h0, 0, 0, "R1 reset op");
        run_op(3'd1, 24'h123456, 16'h0000, 0, 0, "R2 R3 page read");
        run_op(3'd1, 24'hA5C3E1, 16'h0102, 0, 0, "R3 read offset column");
        run_op(3'd2, 24'h00FF10, 16'h1234, 0, 0, "R4 spare read col ignored");
        fail_bit = 0;
        run_op(3'd3, 24'h0B0A09, 16'h0000, 0, 0, "R5 program pass");
        fail_bit = 1;
        run_op(3'd3, 24'h0C0D0E, 16'h0000, 0, 0, "R6 program fail");
        fail_bit = 0;
        run_op(3'd4, 24'h778899, 16'hFFFF, 0, 0, "R7 erase pass");
        fail_bit = 1;
        run_op(3'd4, 24'h112233, 16'h0000, 0, 0, "R7 erase fail");
        fail_bit = 0;
        run_op(3'd1, 24'h000001, 16'h0000, 0, 0, "R6 flag cleared by next op");
        chk(prog_fail == 0, "R6 cleared", prog_fail, 0);

        glitch_en = 1;
        run_op(3'd1, 24'h3C3C3C, 16'h0004, 0, 0, "R8 stale ready edge");
        glitch_en = 0;

        hang = 1; tmo = 12'd20;
        run_op(3'd1, 24'h454545, 16'h0000, 0, 1, "R9 read timeout");
        hang = 0; tmo = 12'd200;
        repeat (30) @(negedge clk);
        run_op(3'd0, 24'h0, 16'h0, 0, 0, "R9 timeout cleared");

        run_op(3'd1, 24'h606162, 16'h0000, 1, 0, "R10 start while busy");

        d0 = dn; l0 = ln;
        @(negedge clk); start = 1'b1; op_i = 3'd6;
        @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        chk(dn == d0 && ln == l0 && fl_ce == 0, "R10 unknown op ignored", dn - d0, 0);

        for (int i = 0; i < 20; i++) begin
            rop = 3'(1 + ($urandom % 4));
            fail_bit = $urandom % 2;
            run_op(rop, 24'($urandom), 16'($urandom % PB), 0, 0, "R2 R5 random op");
        end

        chk(bad_ce == 0, "R11 beats under ce", bad_ce, 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule